// File: doc/BRIEF.md
# Timer Compare-Match Interrupt Unit

This block holds a free-running 32-bit timer and two compare channels that watch it. Each channel owns a compare value and a window over the timer, given by a start bit and a size code. The window is zero-extended on its low side: a channel matches only when the timer bits below the window are all zero and the timer bits inside the window equal the low bits of the compare value. Timer bits above the window are ignored. This lets one channel fire on coarse, aligned boundaries (for example every 1024 counts) while the other tracks a fine, short period.

A match raises that channel's sticky request flag. If the channel is enabled, it also sends a one-cycle pulse on one of two interrupt lines, which a per-channel select bit picks. Each line is the OR of whatever the two channels route to it. Software can set or clear each flag through a write-only action register. A flag set by software never produces a pulse. All configuration arrives through a plain single-cycle register write port.

Top module: `tcm_unit`

## Requirements
- R1: The timer resets to 0. It increments by one on every clock while the run bit (bit 0 of the control register at address 0) is set, and holds otherwise. A write to address 1 loads the timer and takes precedence over the increment in that cycle.
- R2: After reset the timer, both flags and both interrupt lines are 0. All configuration registers are 0, so both channels are disabled and no interrupt line pulses even while the timer runs.
- R3: Channel c has its compare value at address 2+c and its window at address 4+c, with the start position s in bits [4:0] and the size code z in bits [12:8] (the window is z+1 bits wide). While the timer runs, the channel matches when timer[s-1:0] is all zero and timer[s+z:s] equals compare[z:0]. Timer bits above s+z and compare bits above z are ignored. A stopped timer never matches.
- R4: A match event is the transition into a match. A timer value that stays matching over consecutive cycles (for example, reloaded to the same value) gives one event only.
- R5: A match event sets the channel's flag (output irq_flag[c]). The flag stays set until software clears it.
- R6: The interrupt control register at address 6 holds, for channel c, an enable in bit 4c and a line select in bit 4c+1. An event on an enabled channel gives a single-cycle pulse on irq_out[select]. The pulse appears, together with the flag, right after the clock edge that follows the first cycle in which the timer holds the matching value.
- R7: Each interrupt line is the OR of both channels' routed, enabled events. A disabled channel drives no line, but its flag is still set.
- R8: A write to the action register at address 7 sets flag c when bit c is 1 and clears flag c when bit 8+c is 1. Bits written as 0 change nothing.
- R9: Setting a flag by software never produces a pulse on either interrupt line.
- R10: If the set and clear bits of one channel are written together, the flag ends up clear.
- R11: A match event in the same cycle as a software clear of that channel leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| tmr_value | output | 32 | Current timer value |
| irq_out | output | 2 | Interrupt lines, one-cycle pulses |
| irq_flag | output | 2 | Per-channel sticky request flags |

## Verification
The bench sweeps small windows (start 0 to 3, size codes 0 to 2) across both channels and both lines. In each case the compare value carries junk above the window, so a design that compared unmasked bits, forgot the zero condition below the window, or shifted by the wrong amount would pulse at the wrong counts or not at all. Both large aligned window examples are run with a high timer bit set, which catches a design that also compares bits above the window. Reloading a matching value on back-to-back cycles exposes a level-style detector, which would give several pulses. The set/clear collisions and a clear that lands on a hardware match show whether priority is wrong, and a software set with both lines enabled shows whether a set leaks into an interrupt.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  // register map (word addresses)
  localparam int unsigned ADDR_CTRL     = 0;
  localparam int unsigned ADDR_TMR      = 1;
  localparam int unsigned CTRL_RUN_BIT  = 0;
  // field positions
  localparam int unsigned WIN_SIZE_LSB  = 8;
  localparam int unsigned ICR_STRIDE    = 4;
  localparam int unsigned ISR_CLR_LSB   = 8;

  function automatic int unsigned addr_cmp(int unsigned ch);
    return 2 + ch;
  endfunction

  function automatic int unsigned addr_win(int unsigned nch, int unsigned ch);
    return 2 + nch + ch;
  endfunction

  function automatic int unsigned addr_icr(int unsigned nch);
    return 2 + 2 * nch;
  endfunction

  function automatic int unsigned addr_isr(int unsigned nch);
    return 3 + 2 * nch;
  endfunction

endpackage

// File: rtl/tcm_rst_sync.sv
module tcm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tcm_counter.sv
module tcm_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] tmr
);
  logic [W-1:0] tmr_q;
  logic [W-1:0] tmr_d;
  logic         tmr_en;

  always_comb begin
    tmr_en = ld | run;
    tmr_d  = ld ? ld_val : tmr_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  assign tmr = tmr_q;
endmodule

// File: rtl/tcm_chan.sv
module tcm_chan #(
  parameter int unsigned W  = 32,
  parameter int unsigned PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  tmr,
  input  logic          run,
  input  logic [W-1:0]  cmp,
  input  logic [PW-1:0] start,
  input  logic [PW-1:0] size,
  input  logic          sw_set,
  input  logic          sw_clr,
  output logic          hit,
  output logic          flag
);
  localparam int unsigned SW = PW + 1;

  logic [SW-1:0] span;
  logic [W-1:0]  keep_m;
  logic [W-1:0]  fld_m;
  logic [W-1:0]  ref_v;
  logic          eq;
  logic          match;
  logic          match_q;
  logic          flag_q;
  logic          flag_d;
  logic          flag_en;

  // window masks: keep_m covers every bit up to the top of the window,
  // fld_m keeps only the compare bits inside the window width
  always_comb begin
    span = SW'(start) + SW'(size);
    for (int i = 0; i < W; i++) begin
      keep_m[i] = (SW'(i) <= span);
      fld_m[i]  = (SW'(i) <= SW'(size));
    end
    ref_v = (cmp & fld_m) << start;
    eq    = ((tmr ^ ref_v) & keep_m) == '0;
    match = run & eq;
    hit   = match & ~match_q;
  end

  // hardware event beats a clear; clear beats a set
  always_comb begin
    flag_en = hit | sw_set | sw_clr;
    flag_d  = hit | ((flag_q | sw_set) & ~sw_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      match_q <= match;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/tcm_route.sv
module tcm_route #(
  parameter int unsigned NCH  = 2,
  parameter int unsigned NIRQ = 2,
  parameter int unsigned OS_W = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            hit,
  input  logic [NCH-1:0]            en,
  input  logic [NCH-1:0][OS_W-1:0]  sel,
  output logic [NIRQ-1:0]           irq
);
  logic [NIRQ-1:0] irq_q;
  logic [NIRQ-1:0] irq_d;

  always_comb begin
    irq_d = '0;
    for (int k = 0; k < NIRQ; k++) begin
      for (int c = 0; c < NCH; c++) begin
        if (hit[c] && en[c] && (sel[c] == OS_W'(k))) irq_d[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/tcm_unit.sv
module tcm_unit
  import tcm_pkg::*;
#(
  parameter int unsigned TMR_W = 32,
  parameter int unsigned NCH   = 2,
  parameter int unsigned NIRQ  = 2,
  parameter int unsigned AW    = $clog2(4 + 2 * NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [TMR_W-1:0] wr_data,
  output logic [TMR_W-1:0] tmr_value,
  output logic [NIRQ-1:0]  irq_out,
  output logic [NCH-1:0]   irq_flag
);
  localparam int unsigned PW   = $clog2(TMR_W);
  localparam int unsigned OS_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  logic rst_sync_n;

  logic                         run_q,   run_d;
  logic [NCH-1:0][TMR_W-1:0]    cmp_q,   cmp_d;
  logic [NCH-1:0][PW-1:0]       start_q, start_d;
  logic [NCH-1:0][PW-1:0]       size_q,  size_d;
  logic [NCH-1:0]               en_q,    en_d;
  logic [NCH-1:0][OS_W-1:0]     sel_q,   sel_d;

  logic           wr_ctrl, wr_icr, wr_isr, tmr_ld;
  logic [NCH-1:0] wr_cmp, wr_win;
  logic [NCH-1:0] sw_set, sw_clr, ch_hit;

  tcm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // address decode
  always_comb begin
    wr_ctrl = wr_en && (wr_addr == AW'(ADDR_CTRL));
    tmr_ld  = wr_en && (wr_addr == AW'(ADDR_TMR));
    wr_icr  = wr_en && (wr_addr == AW'(addr_icr(NCH)));
    wr_isr  = wr_en && (wr_addr == AW'(addr_isr(NCH)));
    for (int c = 0; c < NCH; c++) begin
      wr_cmp[c] = wr_en && (wr_addr == AW'(addr_cmp(c)));
      wr_win[c] = wr_en && (wr_addr == AW'(addr_win(NCH, c)));
      sw_set[c] = wr_isr && wr_data[c];
      sw_clr[c] = wr_isr && wr_data[ISR_CLR_LSB + c];
    end
  end

  // configuration next state
  always_comb begin
    run_d   = run_q;
    cmp_d   = cmp_q;
    start_d = start_q;
    size_d  = size_q;
    en_d    = en_q;
    sel_d   = sel_q;
    if (wr_ctrl) run_d = wr_data[CTRL_RUN_BIT];
    for (int c = 0; c < NCH; c++) begin
      if (wr_cmp[c]) cmp_d[c] = wr_data;
      if (wr_win[c]) begin
        start_d[c] = wr_data[PW-1:0];
        size_d[c]  = wr_data[WIN_SIZE_LSB +: PW];
      end
      if (wr_icr) begin
        en_d[c]  = wr_data[ICR_STRIDE * c];
        sel_d[c] = wr_data[ICR_STRIDE * c + 1 +: OS_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q   <= 1'b0;
      cmp_q   <= '0;
      start_q <= '0;
      size_q  <= '0;
      en_q    <= '0;
      sel_q   <= '0;
    end else begin
      if (wr_ctrl)   run_q   <= run_d;
      if (|wr_cmp)   cmp_q   <= cmp_d;
      if (|wr_win) begin
        start_q <= start_d;
        size_q  <= size_d;
      end
      if (wr_icr) begin
        en_q  <= en_d;
        sel_q <= sel_d;
      end
    end
  end

  tcm_counter #(.W(TMR_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (run_q),
    .ld     (tmr_ld),
    .ld_val (wr_data),
    .tmr    (tmr_value)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tcm_chan #(.W(TMR_W), .PW(PW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .tmr    (tmr_value),
      .run    (run_q),
      .cmp    (cmp_q[c]),
      .start  (start_q[c]),
      .size   (size_q[c]),
      .sw_set (sw_set[c]),
      .sw_clr (sw_clr[c]),
      .hit    (ch_hit[c]),
      .flag   (irq_flag[c])
    );
  end

  tcm_route #(.NCH(NCH), .NIRQ(NIRQ), .OS_W(OS_W)) u_route (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .hit   (ch_hit),
    .en    (en_q),
    .sel   (sel_q),
    .irq   (irq_out)
  );
endmodule

// File: rtl/tcm_unit_chk.sv
module tcm_unit_chk #(
  parameter int unsigned TMR_W = 32,
  parameter int unsigned NCH   = 2,
  parameter int unsigned NIRQ  = 2
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             run_q,
  input logic             tmr_ld,
  input logic [TMR_W-1:0] tmr_value,
  input logic [NIRQ-1:0]  irq_out,
  input logic [NCH-1:0]   irq_flag,
  input logic [NCH-1:0]   ch_hit,
  input logic [NCH-1:0]   en_q,
  input logic [NCH-1:0]   sw_set,
  input logic [NCH-1:0]   sw_clr
);
  // R1
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q && !tmr_ld) |=> (tmr_value == $past(tmr_value) + TMR_W'(1)));

  // R6
  pulse_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|irq_out) |-> (|irq_flag));

  // R7
  all_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en_q == '0) |=> (irq_out == '0));

  // R9
  sw_set_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((sw_set != '0) && (ch_hit == '0)) |=> (irq_out == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_a
    // R10
    clr_beats_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (sw_set[c] && sw_clr[c] && !ch_hit[c]) |=> !irq_flag[c]);

    // R11
    hit_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ch_hit[c] |=> irq_flag[c]);
  end
endmodule

bind tcm_unit tcm_unit_chk #(.TMR_W(TMR_W), .NCH(NCH), .NIRQ(NIRQ)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .run_q      (run_q),
  .tmr_ld     (tmr_ld),
  .tmr_value  (tmr_value),
  .irq_out    (irq_out),
  .irq_flag   (irq_flag),
  .ch_hit     (ch_hit),
  .en_q       (en_q),
  .sw_set     (sw_set),
  .sw_clr     (sw_clr)
);

// File: tb/tcm_unit_test.sv
module tcm_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int A_CTRL = 0;
  localparam int A_TMR  = 1;
  localparam int A_CMP0 = 2;
  localparam int A_WIN0 = 4;
  localparam int A_ICR  = 6;
  localparam int A_ISR  = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [31:0] tmr_value;
  logic [1:0]  irq_out;
  logic [1:0]  irq_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  tcm_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tmr_value (tmr_value),
    .irq_out   (irq_out),
    .irq_flag  (irq_flag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(int a, logic [31:0] d);
    wr_en   = 1'b1;
    wr_addr = a[2:0];
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
  endtask

  function automatic bit ref_eq(logic [31:0] t, int st, int sz, logic [31:0] cmp);
    logic [63:0] lo_mod, fld_mod;
    lo_mod  = 64'd1 << st;
    fld_mod = 64'd1 << (sz + 1);
    return ((64'(t) % lo_mod) == 0) &&
           (((64'(t) >> st) % fld_mod) == (64'(cmp) % fld_mod));
  endfunction

  task automatic run_window(int c, int st, int sz, logic [31:0] cmp, int os,
                            bit en, logic [31:0] base, int n, string req);
    bit pe, ce, evt, fl;
    logic [1:0] exp_irq;
    pe = 1'b0;
    fl = 1'b0;
    wr(A_CTRL, 0);
    wr(A_TMR, base);
    wr(A_ISR, 32'h0000_0300);
    wr(A_ICR, (32'(en) | (32'(os) << 1)) << (4 * c));
    wr(A_CMP0 + c, cmp);
    wr(A_WIN0 + c, 32'(st) | (32'(sz) << 8));
    wr(A_CTRL, 1);
    for (int j = 0; j < n; j++) begin
      evt = 1'b0;
      if (j >= 1) begin
        ce  = ref_eq(base + 32'(j - 1), st, sz, cmp);
        evt = ce & ~pe;
        pe  = ce;
      end
      fl = fl | evt;
      exp_irq = (evt && en) ? (2'b01 << os) : 2'b00;
      chk("R1 timer", 64'(tmr_value), 64'(base + 32'(j)));
      chk(req, 64'(irq_out), 64'(exp_irq));
      chk("R5 flag", 64'(irq_flag[c]), 64'(fl));
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    int pulses;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 tmr", 64'(tmr_value), 0);
    chk("R2 irq", 64'(irq_out), 0);
    chk("R2 flag", 64'(irq_flag), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 tmr idle", 64'(tmr_value), 0);

    // R1 counting, stop, load priority; R2 channels disabled
    wr(A_CTRL, 1);
    chk("R1 start", 64'(tmr_value), 0);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      chk("R1 count", 64'(tmr_value), 64'(k));
      chk("R2 irq quiet", 64'(irq_out), 0);
    end
    wr(A_CTRL, 0);
    chk("R1 last step", 64'(tmr_value), 11);
    repeat (5) @(negedge clk);
    chk("R1 hold", 64'(tmr_value), 11);
    wr(A_CTRL, 1);
    wr(A_TMR, 500);
    chk("R1 load", 64'(tmr_value), 500);
    @(negedge clk);
    chk("R1 after load", 64'(tmr_value), 501);

    // R3 / R6 sweep over small windows, both channels and lines
    for (int st = 0; st < 4; st++) begin
      for (int sz = 0; sz < 3; sz++) begin
        run_window(st % 2, st, sz, 32'hFFFF_FF00 | 32'(sz + 1),
                   (st + sz) % 2, 1'b1, 32'h0, 40, "R3/R6 sweep");
      end
    end

    // R3 aligned wide windows with a high timer bit set
    run_window(0, 10, 17, 32'h0000_02A5, 0, 1'b1,
               ((32'h2A5 << 10) | 32'h4000_0000) - 32'd2, 6, "R3 wide ch0");
    run_window(1, 7, 7, 32'hABCD_00C3, 1, 1'b1,
               ((32'hC3 << 7) | 32'h8000_0000) - 32'd2, 6, "R3 wide ch1");

    // R7 disabled channel: flag only
    run_window(0, 0, 3, 32'd5, 1, 1'b0, 32'h0, 10, "R7 disabled");

    // R7 both channels on line 1, same value then adjacent values
    wr(A_CTRL, 0);
    wr(A_TMR, 0);
    wr(A_ISR, 32'h300);
    wr(A_ICR, 32'h33);
    wr(A_CMP0, 5);
    wr(A_CMP0 + 1, 5);
    wr(A_WIN0, 32'h300);
    wr(A_WIN0 + 1, 32'h300);
    wr(A_CTRL, 1);
    for (int j = 0; j < 10; j++) begin
      chk("R7 or same", 64'(irq_out), (j == 6) ? 2 : 0);
      @(negedge clk);
    end
    chk("R7 both flags", 64'(irq_flag), 3);
    wr(A_CTRL, 0);
    wr(A_TMR, 0);
    wr(A_CMP0 + 1, 6);
    wr(A_CTRL, 1);
    for (int j = 0; j < 10; j++) begin
      chk("R7 or adjacent", 64'(irq_out), (j == 6 || j == 7) ? 2 : 0);
      @(negedge clk);
    end

    // R4 matching value held by reloading
    wr(A_CTRL, 0);
    wr(A_TMR, 0);
    wr(A_ISR, 32'h300);
    wr(A_ICR, 32'h1);
    wr(A_CMP0, 1);
    wr(A_WIN0, 32'h102);
    wr(A_CTRL, 1);
    pulses = 0;
    for (int k = 0; k < 4; k++) begin
      wr(A_TMR, 4);
      pulses += int'(irq_out[0]);
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      pulses += int'(irq_out[0]);
    end
    chk("R4 single pulse", 64'(pulses), 1);
    chk("R5 flag held", 64'(irq_flag[0]), 1);

    // R8 / R9 / R10 software set and clear, timer stopped
    wr(A_CTRL, 0);
    wr(A_ISR, 32'h300);
    wr(A_ICR, 32'h31);
    wr(A_ISR, 32'h1);
    chk("R8 set ch0", 64'(irq_flag), 1);
    chk("R9 no pulse", 64'(irq_out), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 still quiet", 64'(irq_out), 0);
    end
    wr(A_ISR, 32'h0);
    chk("R8 zero write", 64'(irq_flag), 1);
    wr(A_ISR, 32'h2);
    chk("R8 set ch1", 64'(irq_flag), 3);
    chk("R9 no pulse ch1", 64'(irq_out), 0);
    wr(A_ISR, 32'h100);
    chk("R8 clear ch0", 64'(irq_flag), 2);
    wr(A_ISR, 32'h202);
    chk("R10 clear wins set flag", 64'(irq_flag), 0);
    wr(A_ISR, 32'h101);
    chk("R10 clear wins clear flag", 64'(irq_flag), 0);

    // R11 hardware event in the cycle of a software clear
    wr(A_ICR, 32'h10);
    wr(A_CMP0 + 1, 9);
    wr(A_WIN0 + 1, 32'h300);
    wr(A_TMR, 100);
    wr(A_ISR, 32'h300);
    wr(A_CTRL, 1);
    wr(A_TMR, 9);
    chk("R11 flag before", 64'(irq_flag[1]), 0);
    wr(A_ISR, 32'h200);
    chk("R11 flag kept", 64'(irq_flag[1]), 1);
    chk("R11 pulse", 64'(irq_out), 1);

    finish_up();
  end
endmodule